// File: doc/BRIEF.md
# SDRAM Clock-Enable Power State Controller

This block follows the clock-enable power state of a synchronous DRAM. On every rising clock edge it looks at the clock-enable level of the previous cycle and of the present cycle, the decoded command and an indication that every bank is idle. From these it selects one of five states: normal operation, clock suspend, power-down, self-refresh, or the recovery window that follows self-refresh exit.

A memory controller uses the block to decide whether a command may be executed. The output `cmdBlock` stays high in every state other than normal. A one-cycle `illegal` pulse reports two kinds of request: a power-down or self-refresh entry while a bank is still open, and a wake-up from self-refresh with a command other than no-operation or deselect. The state does not change on such a request. Self-refresh exit is followed by a recovery window of `RECOV_CYC` cycles. Commands stay blocked for the whole window.

Top module: `cke_power_ctrl`

## Requirements
- R1: The command input is coded as follows: 0 = no-operation, 1 = deselect, 2 = activate, 3 = read, 4 = write, 5 = precharge, 6 = auto-refresh, 7 = mode set. The state output is coded as follows: 0 = normal, 1 = clock suspend, 2 = power-down, 3 = self-refresh, 4 = recovery. After reset the state is 0 and both `illegal` and `cmdBlock` are low.
- R2: In normal state, a clock-enable fall (previous 1, current 0) together with auto-refresh and all banks idle moves the state to self-refresh at that edge.
- R3: In normal state, a clock-enable fall together with no-operation or deselect and all banks idle moves the state to power-down at that edge.
- R4: In normal state, a clock-enable fall together with auto-refresh, no-operation or deselect while any bank is active raises `illegal` for one cycle and leaves the state at normal.
- R5: In self-refresh, a clock-enable rise (previous 0, current 1) together with no-operation or deselect moves the state to recovery. The state stays in recovery for exactly `RECOV_CYC` cycles and then returns to normal.
- R6: In self-refresh, a high current clock-enable that is not a valid exit raises `illegal` for one cycle and the state stays at self-refresh. This covers any other command with the rise, and a previous level that was already high.
- R7: In self-refresh or power-down, a low current clock-enable keeps the state unchanged, whatever the command.
- R8: In power-down, a high current clock-enable returns the state to normal at that edge.
- R9: In normal state, a clock-enable fall together with any command other than auto-refresh, no-operation or deselect moves the state to clock suspend. Clock suspend holds while the current clock-enable is low and returns to normal at the first edge where it is high.
- R10: `cmdBlock` is high exactly when the state is not normal.
- R11: During recovery, the clock-enable and command inputs are ignored and `illegal` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ckePrev | input | 1 | Clock-enable level sampled in the previous cycle |
| ckeCur | input | 1 | Clock-enable level in the present cycle |
| cmd | input | 3 | Decoded command (coding in R1) |
| allIdle | input | 1 | High when every bank is precharged |
| powerState | output | 3 | Current power state (coding in R1) |
| illegal | output | 1 | One-cycle flag for a rejected transition |
| cmdBlock | output | 1 | High while commands must not execute |

## Verification
The checker tests on every cycle the one-edge transitions of the block: entry to self-refresh and to power-down, rejection when a bank is busy, rejection of a bad self-refresh wake-up, holding while clock-enable stays low, power-down exit, clock suspend entry and exit, and the absence of `illegal` during recovery. Some behaviour cannot be shown by a single-edge property and needs the bench's scenarios. The exact length of the recovery window, the return to normal at the end of that window, and the fact that a full entry sequence presented during recovery has no effect are examples.

// File: rtl/cke_pkg.sv
package cke_pkg;

  typedef enum logic [2:0] {
    CMD_NOP   = 3'd0,
    CMD_DESEL = 3'd1,
    CMD_ACT   = 3'd2,
    CMD_READ  = 3'd3,
    CMD_WRITE = 3'd4,
    CMD_PRE   = 3'd5,
    CMD_REF   = 3'd6,
    CMD_MRS   = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_SUSPEND = 3'd1,
    ST_PDOWN   = 3'd2,
    ST_SREF    = 3'd3,
    ST_RECOVER = 3'd4
  } pstate_e;

  // strobes from control to the recovery timer
  typedef struct packed {
    logic load;
    logic dec;
  } tmr_strb_t;

endpackage

// File: rtl/cke_timer.sv
module cke_timer #(
  parameter int RECOV_CYC = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  cke_pkg::tmr_strb_t   strb,
  output logic                 lastTick
);
  localparam int CW = $clog2(RECOV_CYC + 1);

  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (strb.load) begin
      count <= CW'(RECOV_CYC);
    end else if (strb.dec && count != '0) begin
      count <= count - CW'(1);
    end
  end

  assign lastTick = (count == CW'(1));

endmodule

// File: rtl/cke_ctrl.sv
module cke_ctrl
  import cke_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ckePrev,
  input  logic      ckeCur,
  input  cmd_e      cmd,
  input  logic      allIdle,
  input  logic      lastTick,
  output pstate_e   state,
  output logic      illegal,
  output tmr_strb_t strb
);
  pstate_e nxt;
  logic    illNxt;
  logic    fallEdge, riseEdge, quiet;

  assign fallEdge = ckePrev & ~ckeCur;
  assign riseEdge = ~ckePrev & ckeCur;
  assign quiet    = (cmd == CMD_NOP) || (cmd == CMD_DESEL);

  always_comb begin
    nxt    = state;
    illNxt = 1'b0;
    strb   = '0;
    case (state)
      ST_NORMAL: begin
        if (fallEdge) begin
          if (cmd == CMD_REF) begin
            if (allIdle) nxt = ST_SREF;
            else         illNxt = 1'b1;
          end else if (quiet) begin
            if (allIdle) nxt = ST_PDOWN;
            else         illNxt = 1'b1;
          end else begin
            nxt = ST_SUSPEND;
          end
        end
      end
      ST_SUSPEND: if (ckeCur) nxt = ST_NORMAL;
      ST_PDOWN:   if (ckeCur) nxt = ST_NORMAL;
      ST_SREF: begin
        if (ckeCur) begin
          if (riseEdge && quiet) begin
            nxt       = ST_RECOVER;
            strb.load = 1'b1;
          end else begin
            illNxt = 1'b1;
          end
        end
      end
      ST_RECOVER: begin
        if (lastTick) nxt = ST_NORMAL;
        else          strb.dec = 1'b1;
      end
      default: nxt = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_NORMAL;
      illegal <= 1'b0;
    end else begin
      state   <= nxt;
      illegal <= illNxt;
    end
  end

endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl #(
  parameter int RECOV_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ckePrev,
  input  logic       ckeCur,
  input  logic [2:0] cmd,
  input  logic       allIdle,
  output logic [2:0] powerState,
  output logic       illegal,
  output logic       cmdBlock
);
  import cke_pkg::*;

  pstate_e   state;
  tmr_strb_t strb;
  logic      lastTick;

  cke_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ckePrev  (ckePrev),
    .ckeCur   (ckeCur),
    .cmd      (cmd_e'(cmd)),
    .allIdle  (allIdle),
    .lastTick (lastTick),
    .state    (state),
    .illegal  (illegal),
    .strb     (strb)
  );

  cke_timer #(.RECOV_CYC(RECOV_CYC)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .lastTick (lastTick)
  );

  assign powerState = state;
  assign cmdBlock   = (state != ST_NORMAL);

endmodule

// File: rtl/cke_power_chk.sv
module cke_power_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ckePrev,
  input logic       ckeCur,
  input logic [2:0] cmd,
  input logic       allIdle,
  input logic [2:0] powerState,
  input logic       illegal,
  input logic       cmdBlock
);
  localparam logic [2:0] S_NORM = 3'd0;
  localparam logic [2:0] S_SUSP = 3'd1;
  localparam logic [2:0] S_PDN  = 3'd2;
  localparam logic [2:0] S_SREF = 3'd3;
  localparam logic [2:0] S_REC  = 3'd4;

  logic fall, rise, quietCmd, refCmd;
  assign fall     = ckePrev & ~ckeCur;
  assign rise     = ~ckePrev & ckeCur;
  assign quietCmd = (cmd == 3'd0) || (cmd == 3'd1);
  assign refCmd   = (cmd == 3'd6);

  assert_sref_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_NORM && fall && refCmd && allIdle) |=> powerState == S_SREF);

  assert_pdown_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_NORM && fall && quietCmd && allIdle) |=> powerState == S_PDN);

  assert_busy_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_NORM && fall && (refCmd || quietCmd) && !allIdle)
      |=> (illegal && powerState == S_NORM));

  assert_sref_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_SREF && rise && quietCmd) |=> powerState == S_REC);

  assert_bad_wake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_SREF && ckeCur && !(rise && quietCmd))
      |=> (illegal && powerState == S_SREF));

  assert_low_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((powerState == S_SREF || powerState == S_PDN) && !ckeCur) |=> $stable(powerState));

  assert_pdown_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_PDN && ckeCur) |=> powerState == S_NORM);

  assert_suspend_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_NORM && fall && !refCmd && !quietCmd) |=> powerState == S_SUSP);

  assert_suspend_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_SUSP && ckeCur) |=> (powerState == S_NORM && !cmdBlock));

  assert_quiet_recovery_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (powerState == S_REC) |=> !illegal);

endmodule

bind cke_power_ctrl cke_power_chk chk (.*);

// File: tb/cke_power_ctrl_test.sv
`timescale 1ns/1ps
module cke_power_ctrl_test;
  localparam int RECOV = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ckePrev = 1'b1, ckeCur = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic       allIdle = 1'b1;
  logic [2:0] powerState;
  logic       illegal, cmdBlock;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cke_power_ctrl #(.RECOV_CYC(RECOV)) uut (
    .clk(clk), .rst_n(rst_n), .ckePrev(ckePrev), .ckeCur(ckeCur),
    .cmd(cmd), .allIdle(allIdle), .powerState(powerState),
    .illegal(illegal), .cmdBlock(cmdBlock)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs and return at the next falling edge
  task automatic step(input logic p, input logic c, input logic [2:0] k, input logic idle);
    ckePrev = p; ckeCur = c; cmd = k; allIdle = idle;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkOut(input string tag, input int st, input int ill);
    check({tag, " state"}, powerState, st);
    check({tag, " illegal"}, illegal, ill);
    check({"R10 block in ", tag}, cmdBlock, (st != 0));
  endtask

  task automatic test_reset();
    checkOut("R1", 0, 0);
  endtask

  task automatic test_pdown();
    step(1, 0, 3'd1, 1); checkOut("R3", 2, 0);
    step(0, 0, 3'd2, 1); checkOut("R7 pdown hold", 2, 0);
    step(0, 1, 3'd0, 1); checkOut("R8", 0, 0);
    step(1, 1, 3'd0, 1);
  endtask

  task automatic test_sref();
    step(1, 0, 3'd6, 1); checkOut("R2", 3, 0);
    step(0, 0, 3'd3, 1); checkOut("R7 sref hold", 3, 0);
    step(0, 1, 3'd3, 1); checkOut("R6 bad cmd", 3, 1);
    step(0, 0, 3'd0, 1); checkOut("R6 pulse end", 3, 0);
    step(1, 1, 3'd0, 1); checkOut("R6 no rise", 3, 1);
    step(0, 0, 3'd0, 1);
    step(0, 1, 3'd1, 1); checkOut("R5 exit", 4, 0);
    for (int i = 1; i < RECOV; i++) begin
      step(1, 0, 3'd6, 1);
      checkOut("R11 recovery", 4, 0);
    end
    step(1, 0, 3'd6, 1); checkOut("R5 recovery end", 0, 0);
    step(1, 1, 3'd0, 1); checkOut("R11 after", 0, 0);
  endtask

  task automatic test_busy();
    step(1, 0, 3'd6, 0); checkOut("R4 ref busy", 0, 1);
    step(1, 0, 3'd0, 0); checkOut("R4 nop busy", 0, 1);
    step(1, 1, 3'd0, 0); checkOut("R4 clear", 0, 0);
  endtask

  task automatic test_suspend();
    step(1, 0, 3'd4, 0); checkOut("R9 enter", 1, 0);
    step(0, 0, 3'd0, 0); checkOut("R9 hold", 1, 0);
    step(0, 1, 3'd3, 0); checkOut("R9 exit", 0, 0);
    step(1, 1, 3'd0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_pdown();
    test_sref();
    test_busy();
    test_suspend();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule